// File: doc/BRIEF.md
# Reference-Ratio Frequency Lock Detector

This block decides whether a clock-recovery loop is frequency-locked to an optional reference clock. Both the reference clock and a divided-down copy of the recovered clock arrive as single-cycle tick enables that are already synchronous to a common measurement clock. The block counts a fixed number of reference ticks per measurement window and counts the divided-clock ticks that fall within that window. At the close of each window it classifies the result.

The oscillator runs at 16, 32 or 128 times the reference. The detector finds this ratio by itself. It picks whichever ratio has an expected count nearest the measured count, and it trusts that choice only when two windows in a row agree. The lock flag is active low and has hysteresis. Lock is lost once the count error reaches a limit derived from LOSE_PPM. Lock is regained only once the error is within a tighter limit derived from GAIN_PPM. Errors between the two limits leave the state as it is.

When the reference-present flag is low, the detector makes no decision of its own and forwards an external lock indication instead.

Top module: `lockdet_refratio`

## Requirements
- R1: After reset, with the reference present, lol_n is low and det_ratio is 0.
- R2: A window closes on the reference tick that makes 2^WIN_LOG2 ticks since counting started. A divided-clock tick in that same cycle is counted toward the closing window, and counting restarts from zero on the next cycle.
- R3: The ratio codes are 0 for 16, 1 for 32 and 2 for 128, and code 3 never appears. The expected count for a ratio is 2^WIN_LOG2 times the ratio divided by PRESCALE. The nearest code wins, and a tie goes to the lower code. det_ratio takes this code on the edge that closes the window.
- R4: A window whose nearest code differs from that of the previous window drives lol_n low. So does the first window after reset or after the reference returns.
- R5: While locked, a confirmed window whose absolute count error is greater than or equal to the lose limit drives lol_n low.
- R6: While unlocked, a confirmed window whose error is at or below the gain limit drives lol_n high. An error strictly between the two limits leaves lol_n unchanged in either state.
- R7: Each limit equals floor(expected count × ppm / 1,000,000) for the nearest ratio, using LOSE_PPM for the lose limit and GAIN_PPM for the gain limit.
- R8: While ref_present is low, lol_n equals ext_lol_n in the same cycle. Window counting is cleared and the lock state and ratio history are dropped. det_ratio keeps its last value.
- R9: The divided-clock count saturates at 2^CW−1, where CW is the number of bits needed to hold twice the largest expected count. It does not wrap.
- R10: With the reference present, lol_n changes only on the edge that closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock edge |
| div_tick | input | 1 | One-cycle pulse per divided recovered-clock edge |
| ref_present | input | 1 | High when a reference clock is supplied |
| ext_lol_n | input | 1 | External active-low loss-of-lock, forwarded when no reference is present |
| lol_n | output | 1 | Active-low loss-of-lock |
| det_ratio | output | 2 | Detected ratio code (0: 16, 1: 32, 2: 128) |

## Verification
The bench builds the block with 512-tick windows, PRESCALE 128, LOSE_PPM 100000 and GAIN_PPM 50000. With these values the expected counts are 64, 128 and 512. A change of a single tick then moves the error across a limit, so each boundary can be hit exactly: an error of 6 against a lose limit of 6, an error of 3 against a gain limit of 3, and a tie at a count of 96. Because the counter is 11 bits wide, a window with a divided tick on every cycle overflows it. A wrapping counter would happen to land on the 128 ratio and lock, so a detector that locks in that case exposes the missing saturation. Randomly chosen ratios and ppm offsets are then checked window by window against a cycle model kept in the bench.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  localparam int NRATIO = 3;

  typedef logic [1:0] ratio_code_t;

  // oscillator-to-reference multiple for each ratio code
  function automatic longint unsigned ratio_of(int idx);
    case (idx)
      0:       return 64'd16;
      1:       return 64'd32;
      default: return 64'd128;
    endcase
  endfunction

  // divided-clock ticks expected in one window for a given ratio code
  function automatic longint unsigned exp_count(int win_log2, int prescale, int idx);
    return ((64'd1 << win_log2) * ratio_of(idx)) / longint'(prescale);
  endfunction

  // count tolerance for an expected count at a given ppm
  function automatic longint unsigned ppm_limit(longint unsigned expv, int ppm);
    return (expv * longint'(ppm)) / 64'd1000000;
  endfunction

  // bits needed to hold a value
  function automatic int bits_for(longint unsigned v);
    int n;
    n = 1;
    while ((64'd1 << n) <= v) n++;
    return n;
  endfunction

endpackage

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int WIN_LOG2 = 16,
  parameter int CW       = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_present,
  input  logic          ref_tick,
  input  logic          div_tick,
  output logic          win_done,
  output logic [CW-1:0] meas,
  output logic [CW-1:0] div_cnt
);
  localparam logic [WIN_LOG2-1:0] LAST_TICK = '1;
  localparam logic [CW-1:0]       CNT_MAX   = '1;

  logic [WIN_LOG2-1:0] ref_cnt;
  logic [CW-1:0]       div_next;

  // saturating increment of the divided-clock count
  always_comb begin
    div_next = div_cnt;
    if (div_tick && (div_cnt != CNT_MAX)) div_next = div_cnt + 1'b1;
  end

  assign win_done = ref_present & ref_tick & (ref_cnt == LAST_TICK);
  assign meas     = div_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      div_cnt <= '0;
    end else if (!ref_present) begin
      ref_cnt <= '0;
      div_cnt <= '0;
    end else begin
      if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
      div_cnt <= win_done ? '0 : div_next;
    end
  end

endmodule

// File: rtl/lockdet_classify.sv
module lockdet_classify
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int PRESCALE = 128,
  parameter int LOSE_PPM = 600,
  parameter int GAIN_PPM = 300,
  parameter int CW       = 18
) (
  input  logic [CW-1:0] meas,
  output ratio_code_t   near_code,
  output logic          lose_hit,
  output logic          gain_hit
);
  logic [CW-1:0] diff   [NRATIO];
  logic [CW-1:0] lose_l [NRATIO];
  logic [CW-1:0] gain_l [NRATIO];
  logic [CW-1:0] best_diff;

  for (genvar i = 0; i < NRATIO; i++) begin : g_ratio
    localparam longint unsigned EXPV = exp_count(WIN_LOG2, PRESCALE, i);
    localparam logic [CW-1:0] EXP_C  = CW'(EXPV);
    localparam logic [CW-1:0] LOSE_C = CW'(ppm_limit(EXPV, LOSE_PPM));
    localparam logic [CW-1:0] GAIN_C = CW'(ppm_limit(EXPV, GAIN_PPM));
    assign diff[i]   = (meas >= EXP_C) ? (meas - EXP_C) : (EXP_C - meas);
    assign lose_l[i] = LOSE_C;
    assign gain_l[i] = GAIN_C;
  end

  // strict comparison keeps the lower code on a tie
  always_comb begin
    near_code = '0;
    best_diff = diff[0];
    for (int i = 1; i < NRATIO; i++) begin
      if (diff[i] < best_diff) begin
        best_diff = diff[i];
        near_code = ratio_code_t'(i);
      end
    end
  end

  assign lose_hit = (best_diff >= lose_l[near_code]);
  assign gain_hit = (best_diff <= gain_l[near_code]);

endmodule

// File: rtl/lockdet_fsm.sv
module lockdet_fsm
  import lockdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_present,
  input  logic        win_done,
  input  ratio_code_t near_code,
  input  logic        lose_hit,
  input  logic        gain_hit,
  output logic        lock_q,
  output logic        confirm,
  output ratio_code_t det_code
);
  ratio_code_t prev_code;
  logic        prev_valid;
  logic        lock_next;

  assign confirm = prev_valid && (near_code == prev_code);

  always_comb begin
    if (!confirm)    lock_next = 1'b0;
    else if (lock_q) lock_next = !lose_hit;
    else             lock_next = gain_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      prev_valid <= 1'b0;
      prev_code  <= '0;
      det_code   <= '0;
    end else if (!ref_present) begin
      lock_q     <= 1'b0;
      prev_valid <= 1'b0;
    end else if (win_done) begin
      lock_q     <= lock_next;
      prev_valid <= 1'b1;
      prev_code  <= near_code;
      det_code   <= near_code;
    end
  end

endmodule

// File: rtl/lockdet_refratio.sv
module lockdet_refratio
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int PRESCALE = 128,
  parameter int LOSE_PPM = 600,
  parameter int GAIN_PPM = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       div_tick,
  input  logic       ref_present,
  input  logic       ext_lol_n,
  output logic       lol_n,
  output logic [1:0] det_ratio
);
  localparam longint unsigned MAX_EXP = exp_count(WIN_LOG2, PRESCALE, NRATIO - 1);
  localparam int CW = bits_for(2 * MAX_EXP);

  logic          win_done;
  logic [CW-1:0] meas;
  logic [CW-1:0] div_cnt;
  ratio_code_t   near_code;
  logic          lose_hit;
  logic          gain_hit;
  logic          lock_q;
  logic          confirm;
  ratio_code_t   det_code;

  lockdet_window #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .ref_present(ref_present),
    .ref_tick(ref_tick), .div_tick(div_tick),
    .win_done(win_done), .meas(meas), .div_cnt(div_cnt)
  );

  lockdet_classify #(
    .WIN_LOG2(WIN_LOG2), .PRESCALE(PRESCALE),
    .LOSE_PPM(LOSE_PPM), .GAIN_PPM(GAIN_PPM), .CW(CW)
  ) u_cls (
    .meas(meas), .near_code(near_code),
    .lose_hit(lose_hit), .gain_hit(gain_hit)
  );

  lockdet_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_present(ref_present),
    .win_done(win_done), .near_code(near_code),
    .lose_hit(lose_hit), .gain_hit(gain_hit),
    .lock_q(lock_q), .confirm(confirm), .det_code(det_code)
  );

  assign lol_n     = ref_present ? lock_q : ext_lol_n;
  assign det_ratio = det_code;

endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
  parameter int CW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_present,
  input logic          win_done,
  input logic [CW-1:0] div_cnt,
  input logic          lock_q,
  input logic          confirm,
  input logic          gain_hit,
  input logic          lose_hit,
  input logic [1:0]    det_ratio
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) det_ratio != 2'd3); // R3
  AST_LOCK_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock_q) |-> $past(confirm)); // R4
  AST_LOSE_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (ref_present && win_done && lock_q && lose_hit) |=> !lock_q); // R5
  AST_GAIN_IN_MARGIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock_q) |-> $past(gain_hit)); // R6
  AST_ABSENT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !ref_present |=> !lock_q); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (ref_present && !win_done && div_cnt == CNT_MAX) |=> div_cnt == CNT_MAX); // R9
  AST_CHANGE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) (ref_present && !win_done) |=> $stable(lock_q)); // R10

endmodule

bind lockdet_refratio lockdet_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_present(ref_present), .win_done(win_done),
  .div_cnt(div_cnt), .lock_q(lock_q), .confirm(confirm),
  .gain_hit(gain_hit), .lose_hit(lose_hit), .det_ratio(det_ratio)
);

// File: tb/sim_lockdet_refratio.sv
`timescale 1ns/1ps
module sim_lockdet_refratio;
  localparam int WLOG = 9;
  localparam int WIN  = 512;
  localparam int PRE  = 128;
  localparam int LOSE = 100000;
  localparam int GAIN = 50000;
  localparam int SATMAX = 2047;  // 11 bits hold twice 512

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, div_tick = 1'b0, ref_present = 1'b1, ext_lol_n = 1'b1;
  logic lol_n;
  logic [1:0] det_ratio;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model state
  int m_rcnt = 0, m_dcnt = 0, m_prev = 0, m_det = 0;
  bit m_pvalid = 0, m_lock = 0, pend = 0;
  string pend_tag = "";

  always #4 clk = ~clk;

  lockdet_refratio #(.WIN_LOG2(WLOG), .PRESCALE(PRE), .LOSE_PPM(LOSE), .GAIN_PPM(GAIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_tick(div_tick),
    .ref_present(ref_present), .ext_lol_n(ext_lol_n), .lol_n(lol_n), .det_ratio(det_ratio)
  );

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic int expect_of(int code);
    int r;
    r = (code == 0) ? 16 : (code == 1) ? 32 : 128;
    return WIN * r / PRE;
  endfunction

  // window evaluation written from the requirements
  task automatic close_window(int cnt, string tag);
    int best, bd, e, d;
    bit conf;
    best = 0; bd = 1 << 30;
    for (int c = 0; c < 3; c++) begin
      e = expect_of(c);
      d = (cnt > e) ? cnt - e : e - cnt;
      if (d < bd) begin bd = d; best = c; end
    end
    e = expect_of(best);
    conf = m_pvalid && (best == m_prev);
    if (!conf) m_lock = 0;
    else if (m_lock) m_lock = !(longint'(bd) >= longint'(e) * LOSE / 1000000);
    else m_lock = (longint'(bd) <= longint'(e) * GAIN / 1000000);
    m_prev = best; m_pvalid = 1; m_det = best;
    pend = 1; pend_tag = tag;
  endtask

  task automatic step(bit rp, bit ext, bit rt, bit dt, string tag);
    int dsum;
    @(negedge clk);
    if (ref_present) chk(lol_n == m_lock, pend ? pend_tag : "R10", "lol_n", lol_n, m_lock);
    else             chk(lol_n == ext_lol_n, "R8", "lol_n passthru", lol_n, ext_lol_n);
    if (pend) begin
      chk(det_ratio == m_det, "R3", "det_ratio", det_ratio, m_det);
      pend = 0;
    end
    ref_present = rp; ext_lol_n = ext; ref_tick = rt; div_tick = dt;
    if (!rp) begin
      m_rcnt = 0; m_dcnt = 0; m_pvalid = 0; m_lock = 0;
    end else begin
      dsum = (dt && m_dcnt != SATMAX) ? m_dcnt + 1 : m_dcnt;
      if (rt && m_rcnt == WIN - 1) begin
        close_window(dsum, tag);
        m_rcnt = 0; m_dcnt = 0;
      end else begin
        if (rt) m_rcnt++;
        m_dcnt = dsum;
      end
    end
    #1;
    if (!rp) chk(lol_n == ext, "R8", "lol_n follows ext", lol_n, ext);
  endtask

  // exact window: k divided ticks placed at start or end, gap idle cycles per tick
  task automatic exact_win(int k, bit at_end, int gap, bit div_in_gap, string tag);
    for (int j = 0; j < WIN; j++) begin
      step(1, 1, 1, at_end ? (j >= WIN - k) : (j < k), tag);
      for (int g = 0; g < gap; g++) step(1, 1, 0, div_in_gap, tag);
    end
  endtask

  // phase-accumulator stimulus: reference every ~3 cycles, ratio r, offset ppm
  task automatic run_acc(int cycles, int r, int ppm, string tag);
    longint unsigned racc, dacc, rinc, dinc;
    real f;
    racc = 0; dacc = 0;
    rinc = 64'd1431655765;
    f = real'(rinc) * real'(r) / real'(PRE) * (1.0 + real'(ppm) / 1.0e6);
    dinc = longint'(f);
    for (int c = 0; c < cycles; c++) begin
      bit rt, dt;
      racc += rinc; dacc += dinc;
      rt = racc >= 64'h1_0000_0000; if (rt) racc -= 64'h1_0000_0000;
      dt = dacc >= 64'h1_0000_0000; if (dt) dacc -= 64'h1_0000_0000;
      step(1, 1, rt, dt, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lol_n == 0, "R1", "lol_n after reset", lol_n, 0);
    chk(det_ratio == 0, "R1", "det_ratio after reset", det_ratio, 0);
    rst_n = 1'b1;
    exact_win(64, 0, 1, 0, "R4");   // first window unconfirmed
    exact_win(64, 0, 1, 0, "R6");   // confirmed, error 0 -> lock
    exact_win(69, 0, 1, 0, "R6");   // error 5, between limits -> hold
    exact_win(70, 1, 1, 0, "R5");   // error 6 reaches lose limit, last tick coincident
    exact_win(61, 1, 1, 0, "R2");   // error 3 only if coincident tick counts
    exact_win(58, 0, 1, 0, "R7");   // error 6 below -> lose
    exact_win(68, 0, 1, 0, "R6");   // error 4, unlocked stays
    exact_win(96, 0, 1, 0, "R3");   // tie 64/128 -> code 0
    exact_win(128, 0, 1, 0, "R4");  // new code 1, unconfirmed
    exact_win(128, 0, 1, 0, "R6");  // lock on ratio 32
    exact_win(512, 0, 1, 0, "R4");  // new code 2
    exact_win(512, 0, 4, 1, "R9");  // 2560 ticks saturate
    exact_win(512, 0, 4, 1, "R9");  // wrap would read 512 and lock
    for (int c = 0; c < 40; c++) step(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, "R8");
    run_acc(3 * 1536 + 40, 32, 0, "R6");
    run_acc(2 * 1536, 32, 80000, "R6");
    run_acc(2 * 1536, 32, 130000, "R5");
    for (int w = 0; w < 12; w++) begin
      int r, p;
      r = (w % 3 == 0) ? 16 : (w % 3 == 1) ? 128 : 32;
      p = int'($urandom_range(0, 300000)) - 150000;
      run_acc(2 * 1536 + int'($urandom_range(0, 600)), r, p, "R5");
      if (w == 6) for (int c = 0; c < 5; c++) step(0, 0, 1, 1, "R8");
    end
    step(1, 1, 0, 0, "R10");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(64'd200000 * 8);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule